// File: doc/BRIEF.md
# Buck Gate Drive Sequencer

This block turns a digital on-time command into the two switch enables of a synchronous buck power stage. All timing comes from one fast clock: a free-running counter marks out a fixed switching period, and within each period the block decides when the upper switch conducts, when the lower switch conducts, and when both are held off so that the two never overlap.

The choice between fully synchronous rectification and light-load diode emulation comes from a single comparator flag that reports whether the sensed current is below a set threshold. In diode emulation the lower switch gets only a short pulse after each upper-switch off edge, so the bootstrap capacitor is topped up without letting inductor current reverse. A command at or above the period length asks for permanent conduction of the upper switch. While that request persists, a bootstrap-low flag is watched period by period, and the block inserts a short refresh slot when the flag has stayed set for too long.

The command word and the mode flag are captured once per period at the wrap of the period counter. Mid-period changes therefore act only from the next period onward. The defaults assume a 100 MHz clock: 333 cycles per period, 3 cycles of dead time and an 8-cycle light-load pulse.

Top module: `buck_gate_seq`

## Requirements
- R1: While `rst_n` is low, both enables and `dcm_mode_o` are low after the next clock edge. The period after reset release runs as a zero-command synchronous period no matter what the inputs carry.
- R2: The period is PERIOD_CLKS cycles. For a command D with 0 < D < PERIOD_CLKS, `hs_en_o` is high at period positions 0 to D-1 and low for the rest of the period.
- R3: `hs_en_o` and `ls_en_o` are never high in the same cycle.
- R4: After one enable falls, the other stays low for at least DEAD_CLKS cycles before it rises.
- R5: With `below_thresh_i` low (synchronous mode), `ls_en_o` is high from position D+DEAD_CLKS through position PERIOD_CLKS-DEAD_CLKS-1. It is low in the last DEAD_CLKS positions of every period.
- R6: With `below_thresh_i` high (diode emulation), `ls_en_o` is high from position D+DEAD_CLKS for PULSE_CLKS cycles. The pulse is cut short at position PERIOD_CLKS-DEAD_CLKS, and `ls_en_o` stays low for the rest of the period.
- R7: A command of 0 gives no `hs_en_o` cycle in that period. The lower switch then starts at position DEAD_CLKS, under the rule of R5 or R6.
- R8: A command of PERIOD_CLKS or more holds `hs_en_o` high in every position, across period boundaries, with `ls_en_o` low.
- R9: If full-conduction periods run back to back and `boot_low_i` is high on every cycle of BOOT_PERIODS+1 of them, the next period is a refresh period. In a refresh period `hs_en_o` is low at positions 0 to 2*DEAD_CLKS+PULSE_CLKS-1, `ls_en_o` is high at positions DEAD_CLKS to DEAD_CLKS+PULSE_CLKS-1, and `hs_en_o` is high for the rest.
- R10: The count of bootstrap-low periods restarts after a refresh period. It also restarts after any period in which `boot_low_i` is low for even one cycle.
- R11: `duty_i` and `below_thresh_i` are captured once per period, on the clock edge at the period's last position. A change made mid-period leaves the rest of that period unchanged.
- R12: `dcm_mode_o` equals the captured mode flag of the current period. It changes only at period position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_i | input | DUTY_W | Upper-switch on-time in clock cycles; PERIOD_CLKS or more means full conduction |
| below_thresh_i | input | 1 | High when the sensed current is below the mode threshold (selects diode emulation) |
| boot_low_i | input | 1 | High when the bootstrap supply is below its minimum |
| hs_en_o | output | 1 | Upper switch enable |
| ls_en_o | output | 1 | Lower switch enable |
| dcm_mode_o | output | 1 | High while the current period runs in diode emulation |

## Verification
Some rules hold cycle by cycle, whatever the inputs do, and the bound checker enforces those: enables never overlap, every rising edge is preceded by the dead gap, the lower switch is quiet at each period's tail, a light-load pulse is never longer than its width, and the mode bit moves only at period start. The exact placement of edges within a period cannot be seen locally, so the directed scenarios cover it. These include the on-time for a given command, truncation of the light-load pulse near the period end, and the boundary between 332 and 333. The scenarios also show which period the refresh lands in and how a one-cycle drop of the bootstrap flag pushes it back.

// File: rtl/bgs_pkg.sv
// Shared types for the buck gate drive sequencer.
// Assumes: consumers import the package; no state lives here.
package bgs_pkg;

    // Which switch the sequencer wants on in a given position; one value only,
    // so the two enables can never be requested together.
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_HIGH = 2'd1,
        DRV_LOW  = 2'd2
    } drive_e;

    // Per-period operating mode captured at the period wrap.
    typedef struct packed {
        logic light;    // diode emulation selected for this period
        logic full;     // command asks for full conduction
        logic refresh;  // this period is a bootstrap refresh slot
    } period_mode_t;

endpackage

// File: rtl/bgs_period_timer.sv
// Free-running switching period counter.
// Counts 0 .. PERIOD_CLKS-1 and flags the last position so that period-wide
// state can be captured on that edge. Assumes PERIOD_CLKS >= 2.
module bgs_period_timer #(
    parameter int PERIOD_CLKS = 333,
    parameter int POS_W       = $clog2(PERIOD_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos_o,
    output logic             wrap_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PERIOD_CLKS - 1);

    logic [POS_W-1:0] pos_q;

    assign wrap_o = (pos_q == LAST_POS);
    assign pos_o  = pos_q;

    // Advance the position, returning to zero after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (wrap_o) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/bgs_boot_monitor.sv
// Bootstrap supply watchdog for full-conduction operation.
// Counts consecutive full periods in which the bootstrap-low flag was set on
// every cycle, and asks for a refresh slot once the count passes BOOT_PERIODS.
// Assumes wrap_i is high for exactly one cycle per period.
module bgs_boot_monitor #(
    parameter int BOOT_PERIODS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic boot_low_i,
    input  logic cur_full_i,
    input  logic next_full_i,
    output logic refresh_next_o
);

    localparam int CNT_W = $clog2(BOOT_PERIODS + 2);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BOOT_PERIODS);

    logic             held_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    // Count the ending period only if it was a plain full period with the flag held.
    always_comb begin
        cnt_nx         = (cur_full_i && held_q && boot_low_i) ? (cnt_q + 1'b1) : '0;
        refresh_next_o = next_full_i && (cnt_nx > LIMIT);
    end

    // Track whether the flag stayed high and update the period count at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b1;
            cnt_q  <= '0;
        end else if (wrap_i) begin
            held_q <= 1'b1;
            cnt_q  <= (refresh_next_o || !next_full_i) ? '0 : cnt_nx;
        end else if (!boot_low_i) begin
            held_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bgs_period_latch.sv
// Once-per-period capture of the command word and mode flag.
// Inputs are sampled only on the wrap edge, so mid-period changes wait for
// the next period. Reset loads a zero command in synchronous mode.
module bgs_period_latch
    import bgs_pkg::*;
#(
    parameter int PERIOD_CLKS = 333,
    parameter int DUTY_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              light_i,
    input  logic              refresh_next_i,
    output logic [DUTY_W-1:0] duty_o,
    output period_mode_t      mode_o,
    output logic              next_full_o,
    output logic              cur_full_o
);

    localparam int CW = ((DUTY_W > $clog2(PERIOD_CLKS)) ? DUTY_W : $clog2(PERIOD_CLKS)) + 1;
    localparam logic [CW-1:0] FULL_AT = CW'(PERIOD_CLKS);

    logic [DUTY_W-1:0] duty_q;
    period_mode_t      mode_q;

    // A command at or above the period length is the full-conduction request.
    assign next_full_o = (CW'(duty_i) >= FULL_AT);
    assign cur_full_o  = mode_q.full && !mode_q.refresh;
    assign duty_o      = duty_q;
    assign mode_o      = mode_q;

    // Capture the next period's settings on the wrap edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            mode_q <= '0;
        end else if (wrap_i) begin
            duty_q         <= duty_i;
            mode_q.light   <= light_i;
            mode_q.full    <= next_full_o;
            mode_q.refresh <= refresh_next_i;
        end
    end

endmodule

// File: rtl/bgs_phase_gen.sv
// Per-position switch decision and registered gate enables.
// From the period position and the captured settings it picks one drive
// state (upper on, lower on, or both off) and registers it onto the outputs.
// Assumes 2*DEAD_CLKS+PULSE_CLKS < PERIOD_CLKS.
module bgs_phase_gen
    import bgs_pkg::*;
#(
    parameter int PERIOD_CLKS = 333,
    parameter int DEAD_CLKS   = 3,
    parameter int PULSE_CLKS  = 8,
    parameter int DUTY_W      = 9,
    parameter int POS_W       = $clog2(PERIOD_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  period_mode_t      mode_i,
    output logic              hs_en_o,
    output logic              ls_en_o,
    output logic              dcm_mode_o
);

    localparam int CW = ((DUTY_W > POS_W) ? DUTY_W : POS_W) + 2;
    localparam logic [CW-1:0] K_DEAD     = CW'(DEAD_CLKS);
    localparam logic [CW-1:0] K_PULSE    = CW'(PULSE_CLKS);
    localparam logic [CW-1:0] K_TAIL     = CW'(PERIOD_CLKS - DEAD_CLKS);
    localparam logic [CW-1:0] K_RF_LSEND = CW'(DEAD_CLKS + PULSE_CLKS);
    localparam logic [CW-1:0] K_RF_HSON  = CW'(2 * DEAD_CLKS + PULSE_CLKS);

    logic [CW-1:0] p_ext;
    logic [CW-1:0] d_ext;
    logic [CW-1:0] ls_start;
    logic [CW-1:0] pulse_end;
    logic [CW-1:0] ls_end;
    drive_e        want;
    logic          hs_q;
    logic          ls_q;
    logic          dcm_q;

    // Window edges for the lower switch in this period.
    always_comb begin
        p_ext     = CW'(pos_i);
        d_ext     = CW'(duty_i);
        ls_start  = d_ext + K_DEAD;
        pulse_end = ls_start + K_PULSE;
        if (mode_i.light) begin
            ls_end = (pulse_end < K_TAIL) ? pulse_end : K_TAIL;
        end else begin
            ls_end = K_TAIL;
        end
    end

    // Choose exactly one drive state for the current position.
    always_comb begin
        if (mode_i.refresh) begin
            if (p_ext < K_DEAD) begin
                want = DRV_OFF;
            end else if (p_ext < K_RF_LSEND) begin
                want = DRV_LOW;
            end else if (p_ext < K_RF_HSON) begin
                want = DRV_OFF;
            end else begin
                want = DRV_HIGH;
            end
        end else if (mode_i.full) begin
            want = DRV_HIGH;
        end else if (p_ext < d_ext) begin
            want = DRV_HIGH;
        end else if ((p_ext >= ls_start) && (p_ext < ls_end)) begin
            want = DRV_LOW;
        end else begin
            want = DRV_OFF;
        end
    end

    // Register the enables and the mode status so they change together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            ls_q  <= 1'b0;
            dcm_q <= 1'b0;
        end else begin
            hs_q  <= (want == DRV_HIGH);
            ls_q  <= (want == DRV_LOW);
            dcm_q <= mode_i.light;
        end
    end

    assign hs_en_o    = hs_q;
    assign ls_en_o    = ls_q;
    assign dcm_mode_o = dcm_q;

endmodule

// File: rtl/buck_gate_seq.sv
// Buck converter gate drive sequencer, top level.
// Wires the period timer, the per-period capture, the bootstrap watchdog and
// the phase generator. Assumes one clock domain and that the inputs are
// already synchronous to clk.
module buck_gate_seq
    import bgs_pkg::*;
#(
    parameter int PERIOD_CLKS  = 333,
    parameter int DEAD_CLKS    = 3,
    parameter int PULSE_CLKS   = 8,
    parameter int BOOT_PERIODS = 3,
    parameter int DUTY_W       = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              below_thresh_i,
    input  logic              boot_low_i,
    output logic              hs_en_o,
    output logic              ls_en_o,
    output logic              dcm_mode_o
);

    localparam int POS_W = $clog2(PERIOD_CLKS);

    logic [POS_W-1:0]  period_pos;
    logic              period_wrap;
    logic [DUTY_W-1:0] cap_duty;
    period_mode_t      cap_mode;
    logic              next_full;
    logic              cur_full;
    logic              refresh_next;

    bgs_period_timer #(
        .PERIOD_CLKS(PERIOD_CLKS),
        .POS_W      (POS_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_o (period_pos),
        .wrap_o(period_wrap)
    );

    bgs_period_latch #(
        .PERIOD_CLKS(PERIOD_CLKS),
        .DUTY_W     (DUTY_W)
    ) u_latch (
        .clk           (clk),
        .rst_n         (rst_n),
        .wrap_i        (period_wrap),
        .duty_i        (duty_i),
        .light_i       (below_thresh_i),
        .refresh_next_i(refresh_next),
        .duty_o        (cap_duty),
        .mode_o        (cap_mode),
        .next_full_o   (next_full),
        .cur_full_o    (cur_full)
    );

    bgs_boot_monitor #(
        .BOOT_PERIODS(BOOT_PERIODS)
    ) u_boot (
        .clk           (clk),
        .rst_n         (rst_n),
        .wrap_i        (period_wrap),
        .boot_low_i    (boot_low_i),
        .cur_full_i    (cur_full),
        .next_full_i   (next_full),
        .refresh_next_o(refresh_next)
    );

    bgs_phase_gen #(
        .PERIOD_CLKS(PERIOD_CLKS),
        .DEAD_CLKS  (DEAD_CLKS),
        .PULSE_CLKS (PULSE_CLKS),
        .DUTY_W     (DUTY_W),
        .POS_W      (POS_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos_i     (period_pos),
        .duty_i    (cap_duty),
        .mode_i    (cap_mode),
        .hs_en_o   (hs_en_o),
        .ls_en_o   (ls_en_o),
        .dcm_mode_o(dcm_mode_o)
    );

endmodule

// File: rtl/bgs_checker.sv
// Cycle-level rules of the gate drive sequencer, bound to the top module.
// Watches the enables, the mode bit and the period position; the dead-gap
// and pulse-length windows use counters so no parameter sets a delay depth.
module bgs_checker #(
    parameter int PERIOD_CLKS = 333,
    parameter int DEAD_CLKS   = 3,
    parameter int PULSE_CLKS  = 8,
    parameter int POS_W       = $clog2(PERIOD_CLKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_en,
    input logic             ls_en,
    input logic             dcm_mode,
    input logic [POS_W-1:0] pos
);

    localparam int GAP_W = $clog2(DEAD_CLKS + 1) + 1;
    localparam int RUN_W = $clog2(PULSE_CLKS + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(DEAD_CLKS);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PULSE_CLKS);
    localparam logic [POS_W-1:0] TAIL_AFTER = POS_W'(PERIOD_CLKS - DEAD_CLKS);

    logic [GAP_W-1:0] hs_gap;
    logic [GAP_W-1:0] ls_gap;
    logic [RUN_W-1:0] ls_run;

    // Cycles each enable has been low, saturating at the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_gap <= GAP_MAX;
            ls_gap <= GAP_MAX;
        end else begin
            hs_gap <= hs_en ? '0 : ((hs_gap < GAP_MAX) ? hs_gap + 1'b1 : hs_gap);
            ls_gap <= ls_en ? '0 : ((ls_gap < GAP_MAX) ? ls_gap + 1'b1 : ls_gap);
        end
    end

    // Length of the current lower-switch run, saturating just past the pulse width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_run <= '0;
        end else if (ls_en) begin
            ls_run <= (ls_run <= RUN_MAX) ? ls_run + 1'b1 : ls_run;
        end else begin
            ls_run <= '0;
        end
    end

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!hs_en && !ls_en && !dcm_mode));

    assert_dead_before_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> (hs_gap >= GAP_MAX));

    assert_dead_before_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> (ls_gap >= GAP_MAX));

    assert_low_quiet_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos == '0) || (pos > TAIL_AFTER)) |-> !ls_en);

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dcm_mode && ls_en) |-> (ls_run < RUN_MAX));

    assert_mode_at_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dcm_mode) |-> (pos == POS_W'(1)));

endmodule

bind buck_gate_seq bgs_checker #(
    .PERIOD_CLKS(PERIOD_CLKS),
    .DEAD_CLKS  (DEAD_CLKS),
    .PULSE_CLKS (PULSE_CLKS),
    .POS_W      (POS_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_en   (hs_en_o),
    .ls_en   (ls_en_o),
    .dcm_mode(dcm_mode_o),
    .pos     (period_pos)
);

// File: tb/buck_gate_seq_test.sv
// Directed bench for the gate drive sequencer: one task per scenario, each
// comparing whole periods against the waveform the requirements describe.
module buck_gate_seq_test;

    localparam int N  = 333;
    localparam int DT = 3;
    localparam int PW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] duty = 9'd0;
    logic       light = 1'b0;
    logic       boot = 1'b0;
    logic       hs, ls, dcm;

    int total = 0;
    int bad = 0;
    int ecount = 0;
    bit done = 0;

    buck_gate_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .duty_i        (duty),
        .below_thresh_i(light),
        .boot_low_i    (boot),
        .hs_en_o       (hs),
        .ls_en_o       (ls),
        .dcm_mode_o    (dcm)
    );

    always #2 clk = ~clk;

    // One clock edge, then settle at the following falling edge.
    task automatic step();
        @(posedge clk);
        ecount++;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected enables at a period position, written from R2 and R5 to R9.
    function automatic void expect_at(input int p, input int d, input bit lt, input bit rf,
                                      output bit eh, output bit el);
        int st, en;
        if (rf) begin
            eh = (p >= 2 * DT + PW);
            el = (p >= DT) && (p < DT + PW);
        end else if (d >= N) begin
            eh = 1'b1;
            el = 1'b0;
        end else begin
            eh = (p < d);
            st = d + DT;
            en = lt ? ((st + PW < N - DT) ? st + PW : N - DT) : N - DT;
            el = (p >= st) && (p < en);
        end
    endfunction

    // Play one period and compare it; next settings go in mid-period (R11).
    task automatic play_period(input int d, input bit lt, input bit rf,
                               input int nd, input bit nlt, input int glitch,
                               input string tag);
        int hs_bad = 0, ls_bad = 0, md_bad = 0;
        int hs_pos = -1, ls_pos = -1;
        bit hs_act = 0, ls_act = 0, hs_exp = 0, ls_exp = 0;
        for (int p = 0; p < N; p++) begin
            bit eh, el;
            if (p == glitch) boot = 1'b0;
            if (glitch >= 0 && p == glitch + 1) boot = 1'b1;
            if (p == N / 2) begin
                duty  = 9'(nd);
                light = nlt;
            end
            step();
            expect_at(p, d, lt, rf, eh, el);
            if (hs !== eh) begin
                if (hs_bad == 0) begin hs_pos = p; hs_act = hs; hs_exp = eh; end
                hs_bad++;
            end
            if (ls !== el) begin
                if (ls_bad == 0) begin ls_pos = p; ls_act = ls; ls_exp = el; end
                ls_bad++;
            end
            if (dcm !== lt) md_bad++;
        end
        check($sformatf("%s high-side pos %0d", tag, hs_pos), hs_bad == 0, hs_act, hs_exp);
        check($sformatf("%s low-side pos %0d", tag, ls_pos), ls_bad == 0, ls_act, ls_exp);
        check($sformatf("%s R12 mode bit mismatches", tag), md_bad == 0, md_bad, 0);
    endtask

    // R1: quiet during reset, then a zero-command synchronous first period.
    task automatic t_reset();
        duty = 9'd400; light = 1'b1; boot = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R1 enables low in reset", (hs === 1'b0) && (ls === 1'b0) && (dcm === 1'b0),
                  {hs, ls, dcm}, 0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        ecount = 0;
        play_period(0, 0, 0, 100, 0, -1, "R1 R7 first period");
    endtask

    // R2 R5: synchronous periods with two commands.
    task automatic t_sync();
        play_period(100, 0, 0, 200, 0, -1, "R2 R5 d100");
        play_period(200, 0, 0, 100, 1, -1, "R2 R5 d200");
    endtask

    // R6: light-load pulse, plain and cut short near the period end.
    task automatic t_light();
        play_period(100, 1, 0, 320, 1, -1, "R6 d100");
        play_period(320, 1, 0, 0, 0, -1, "R6 truncated d320");
    endtask

    // R7: zero command in both modes.
    task automatic t_zero();
        play_period(0, 0, 0, 0, 1, -1, "R7 sync zero");
        play_period(0, 1, 0, 332, 0, -1, "R7 light zero");
    endtask

    // R8: one below the period, exactly the period, and above it.
    task automatic t_full();
        play_period(332, 0, 0, 333, 0, -1, "R2 d332");
        play_period(333, 0, 0, 511, 1, -1, "R8 d333");
        play_period(511, 1, 0, 400, 0, -1, "R8 d511 light");
        play_period(400, 0, 0, 400, 0, -1, "R8 d400");
    endtask

    // R9 R10: refresh after four flagged periods, restart, and a one-cycle drop.
    task automatic t_boot();
        boot = 1'b1;
        for (int k = 0; k < 17; k++) begin
            bit rf = (k == 4) || (k == 9) || (k == 16);
            int nd = (k == 16) ? 50 : 400;
            play_period(400, 0, rf, nd, 0, (k == 11) ? 100 : -1,
                        $sformatf("R9 R10 boot period %0d", k));
        end
        boot = 1'b0;
        play_period(50, 0, 0, 50, 0, -1, "R2 back from full");
    endtask

    // R1: reset in mid-period restarts the counter with zero-command settings.
    task automatic t_reset_again();
        for (int i = 0; i < 40; i++) step();
        rst_n = 1'b0;
        duty = 9'd200; light = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 enables low after mid-period reset", (hs === 1'b0) && (ls === 1'b0), {hs, ls}, 0);
        rst_n = 1'b1;
        ecount = 0;
        play_period(0, 0, 0, 200, 1, -1, "R1 restart period");
        play_period(200, 1, 0, 200, 1, -1, "R6 R11 after restart");
    endtask

    initial begin
        t_reset();
        t_sync();
        t_light();
        t_zero();
        t_full();
        t_boot();
        t_reset_again();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", ecount, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule